// File: doc/BRIEF.md
# Multi-Channel Temperature Sampling Sequencer

This block sits in front of a temperature-sensing front end and runs it under register control. Software writes a primary control word that starts, enables or holds the measurement path, picks the internal sensor or one of up to sixteen external channels, sets the conversion rate, and can switch averaging off. A secondary control word sets the log2 of the number of samples to average. The block steers the front end to the chosen source and issues one conversion strobe per sample period. It averages 2^N raw 10-bit two's-complement codes and publishes the mean, with a valid flag, in a status word.

The valid flag drops on every change of source and every stop. It comes back only after a settling delay and one complete average on the new source. Software therefore polls the flag after retuning the source and never reads a code that mixes two sensors. The settling delay and the base sample period are parameters counted in clock cycles, so a simulation can use short values.

Top module: `temp_sample_seq`

## Requirements
- R1: After reset the primary control word reads 0, the secondary control word reads 1 (two-sample averaging), the status word reads 0 and no conversion strobe is issued.
- R2: Primary control bit 0 is start, bit 1 holds the sensor in reset and bit 2 enables it. Conversions run only while start=1, enable=1 and reset=0.
- R3: The mode sits in primary bits 31:30. Value 2 selects an external channel and drives `fe_sel` to the channel field (bits 16:13) plus one. Any other mode value selects the internal sensor (`fe_sel`=0), and the channel field is then ignored: changing it neither restarts the sequencer nor drops valid.
- R4: After the measurement path turns on, or after a source change, the first conversion strobe comes SETTLE_CYC+1 cycles after the clock edge that wrote the control word.
- R5: Primary bits 25:24 (rate, r) set the spacing between conversion strobes to PERIOD_UNIT << (3−r) cycles, so r=3 is the fastest rate.
- R6: The secondary word's bits 2:0 give N. The published code is the mean of 2^N consecutive samples. Primary bit 6 set bypasses averaging, and each sample is then published on its own.
- R7: The status word carries the result in bits 9:0 and the valid flag in bit VALID_BIT (16 by default); all other bits read 0. Result and valid update on the clock edge that takes the last sample of an average.
- R8: A change of source while running clears valid and discards the partial average on the next edge. Valid returns only after the settling delay and a full average on the new source.
- R9: Clearing start, setting reset or clearing enable clears valid and the accumulator on the next edge, and no partial average is kept.
- R10: Register addresses: 0 is the primary word, 1 is the secondary word (only bits 2:0 stored, others read 0), 2 is status and 3 reads 0. Writes to addresses 2 and 3 have no effect.
- R11: Averaging treats codes as signed 10-bit values and rounds toward minus infinity. For example, the mean of 0x3FF (−1) and 0x000 is 0x3FF.
- R12: Between averages the published result is held unchanged, and valid stays set while the same source keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| fe_conv | output | 1 | One-cycle conversion strobe; the front end's code is taken on this cycle |
| fe_sel | output | 5 | Source select: 0 internal, k external channel k |
| fe_code | input | 10 | Raw code from the selected source |

## Verification
The assertions watch, on every cycle, that strobes only happen while the path is enabled and after the full settling window, that a stop or a source change takes valid down on the next edge, that valid rises only right after a strobe, that the result holds between strobes, and that internal mode never selects an external channel. Only the bench's scenarios can show the numbers: the exact strobe latency and period for each rate, the means of signed code streams under different averaging lengths and bypass, the register map and ignored writes, and valid returning after a full average on the new source. A behavioural model in the bench predicts strobes, select and read data for every cycle.

// File: rtl/temp_sample_seq.sv
`timescale 1ns/100ps
module temp_sample_seq #(
  parameter int SETTLE_CYC  = 3750000,
  parameter int PERIOD_UNIT = 500000,
  parameter int VALID_BIT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        fe_conv,
  output logic [4:0]  fe_sel,
  input  logic [9:0]  fe_code
);
  localparam int SW = $clog2(SETTLE_CYC + 2);
  localparam int PW = $clog2((PERIOD_UNIT << 3) + 2);
  localparam int AW = 17;

  logic [31:0] ctrl_a;
  logic [2:0]  ctrl_b;
  logic        run_q;
  logic [4:0]  src_q;
  logic [SW-1:0] settle_q;
  logic [PW-1:0] gap_q;
  logic signed [AW-1:0] acc_q;
  logic [7:0]  cnt_q;
  logic [9:0]  res_q;
  logic        valid_q;

  wire go     = ctrl_a[0] & ctrl_a[2] & ~ctrl_a[1];
  wire is_ext = (ctrl_a[31:30] == 2'd2);
  assign fe_sel = is_ext ? ({1'b0, ctrl_a[16:13]} + 5'd1) : 5'd0;

  wire restart = go & (~run_q | (fe_sel != src_q));
  assign fe_conv = go & ~restart & (settle_q == '0) & (gap_q == '0);

  wire [2:0]    n_log  = ctrl_a[6] ? 3'd0 : ctrl_b;
  wire [7:0]    target = 8'((9'd1 << n_log) - 9'd1);
  wire [PW-1:0] period = PW'(PERIOD_UNIT) << (2'd3 - ctrl_a[25:24]);
  wire signed [AW-1:0] code_x = {{(AW-10){fe_code[9]}}, fe_code};
  wire signed [AW-1:0] sum    = acc_q + code_x;
  wire signed [AW-1:0] avg    = sum >>> n_log;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= '0;
      ctrl_b <= 3'd1;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) ctrl_a <= reg_wdata;
      if (reg_addr == 2'd1) ctrl_b <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      src_q    <= '0;
      settle_q <= '0;
      gap_q    <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      res_q    <= '0;
      valid_q  <= 1'b0;
    end else if (!go) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else if (restart) begin
      run_q    <= 1'b1;
      src_q    <= fe_sel;
      settle_q <= SW'(SETTLE_CYC);
      gap_q    <= '0;
      valid_q  <= 1'b0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else if (settle_q != '0) begin
      settle_q <= settle_q - 1'b1;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end else begin
      gap_q <= period - 1'b1;
      if (cnt_q >= target) begin
        res_q   <= avg[9:0];
        valid_q <= 1'b1;
        acc_q   <= '0;
        cnt_q   <= '0;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  wire [31:0] status = (32'(valid_q) << VALID_BIT) | {22'd0, res_q};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl_a;
      2'd1:    reg_rdata = {29'd0, ctrl_b};
      2'd2:    reg_rdata = status;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/temp_sample_seq_chk.sv
`timescale 1ns/100ps
module temp_sample_seq_chk #(
  parameter int SETTLE_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       is_ext,
  input logic       fe_conv,
  input logic [4:0] fe_sel,
  input logic       run_q,
  input logic [4:0] src_q,
  input logic       valid_q,
  input logic [9:0] res_q
);
  int unsigned since_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !go || !run_q || fe_sel != src_q) since_q <= 0;
    else if (since_q < SETTLE_CYC) since_q <= since_q + 1;
  end

  assert_conv_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fe_conv |-> go);
  assert_internal_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ext |-> fe_sel == 5'd0);
  assert_settle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fe_conv |-> since_q >= SETTLE_CYC);
  assert_valid_after_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(fe_conv));
  assert_src_change_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && run_q && fe_sel != src_q) |=> !valid_q);
  assert_stop_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !valid_q);
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_conv |=> $stable(res_q));
endmodule

bind temp_sample_seq temp_sample_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .is_ext(is_ext), .fe_conv(fe_conv),
  .fe_sel(fe_sel), .run_q(run_q), .src_q(src_q), .valid_q(valid_q), .res_q(res_q)
);

// File: tb/tb_temp_sample_seq.sv
`timescale 1ns/100ps
module tb_temp_sample_seq;
  localparam int S = 10;
  localparam int U = 2;
  localparam logic [31:0] RUN = 32'h5;
  localparam logic [31:0] BYP = 32'h40;

  logic clk = 0, rst_n = 0, wr = 0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic conv;
  logic [4:0] sel;
  logic [9:0] code;
  int kidx [32];
  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  function automatic logic [9:0] stream(int c, int k);
    if (c == 3) return (k % 2 == 0) ? 10'h3FF : 10'h000;
    return 10'((c * 97 + k * 29 + 5) & 32'h3FF);
  endfunction

  assign code = stream(int'(sel), kidx[sel]);

  temp_sample_seq #(.SETTLE_CYC(S), .PERIOD_UNIT(U), .VALID_BIT(16)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .fe_conv(conv), .fe_sel(sel), .fe_code(code));

  function automatic logic [31:0] osr(int r); return 32'(r) << 24; endfunction
  function automatic logic [31:0] ext(int ch); return (32'd2 << 30) | (32'(ch) << 13); endfunction

  // behavioural reference
  logic [31:0] ma; logic [2:0] mb; logic [9:0] mres;
  bit mrun, mval, mconv_last;
  int msrc, mwait, mgap, mconv_src, mn, msum;
  int q [$];

  function automatic bit m_act(logic [31:0] a); return a[0] && a[2] && !a[1]; endfunction
  function automatic int m_src(logic [31:0] a);
    return (a[31:30] == 2'd2) ? int'(a[16:13]) + 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ma = 0; mb = 3'd1; mres = 0; mrun = 0; mval = 0; msrc = 0;
      mwait = 0; mgap = 0; mconv_last = 0; q.delete();
    end else begin
      mconv_last = 0;
      if (!m_act(ma)) begin
        mrun = 0; mval = 0; q.delete();
      end else if (!mrun || m_src(ma) != msrc) begin
        mrun = 1; msrc = m_src(ma); mwait = S; mgap = 0; mval = 0; q.delete();
      end else if (mwait > 0) mwait--;
      else if (mgap > 0) mgap--;
      else begin
        mconv_last = 1; mconv_src = msrc;
        mgap = (U << (3 - int'(ma[25:24]))) - 1;
        q.push_back(code[9] ? int'(code) - 1024 : int'(code));
        mn = ma[6] ? 0 : int'(mb);
        if (q.size() >= (1 << mn)) begin
          msum = 0;
          foreach (q[i]) msum += q[i];
          mres = 10'(msum >>> mn); mval = 1; q.delete();
        end
      end
      if (wr && addr == 2'd0) ma = wdata;
      if (wr && addr == 2'd1) mb = wdata[2:0];
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    bit exp_conv;
    #0.5;
    if (rst_n) begin
      exp_conv = mrun && m_act(ma) && m_src(ma) == msrc && mwait == 0 && mgap == 0;
      case (addr)
        2'd0: exp_rd = ma;
        2'd1: exp_rd = {29'd0, mb};
        2'd2: exp_rd = (32'(mval) << 16) | {22'd0, mres};
        default: exp_rd = 0;
      endcase
      chk(conv == exp_conv, cur_req, "model conv", 32'(conv), 32'(exp_conv));
      chk(sel == 5'(m_src(ma)), cur_req, "model sel", 32'(sel), 32'(m_src(ma)));
      chk(rdata == exp_rd, cur_req, "model rdata", rdata, exp_rd);
    end
    if (mconv_last) kidx[mconv_src]++;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(0, "watchdog", "cycles", 32'(cyc), 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic wait_conv(output int n);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!conv && n < 2000);
  endtask

  task automatic wait_valid();
    int n = 0;
    addr = 2'd2;
    do begin @(negedge clk); #1; n++; end while (!rdata[16] && n < 5000);
    chk(rdata[16], cur_req, "valid returned", rdata, 32'h10000);
  endtask

  initial begin
    logic [31:0] v, s;
    int n;
    logic [9:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(2'd0, v); chk(v == 0, "R1", "ctrl_a reset", v, 0);
    rd(2'd1, v); chk(v == 1, "R1", "ctrl_b reset", v, 1);
    rd(2'd2, v); chk(v == 0, "R1", "status reset", v, 0);
    chk(conv == 0, "R1", "no conv", 32'(conv), 0);

    // R4, R5, R7
    cur_req = "R4";
    wr_reg(2'd0, RUN | osr(3));
    wait_conv(n); chk(n == S + 1, "R4", "first conv latency", n, S + 1);
    cur_req = "R5";
    wait_conv(n); chk(n == U, "R5", "period r=3", n, U);
    cur_req = "R7";
    wait_valid();
    chk((rdata & ~32'h103FF) == 0, "R7", "status unused bits", rdata, rdata & 32'h103FF);
    cur_req = "R5";
    wr_reg(2'd0, RUN | osr(0));
    wait_conv(n); wait_conv(n);
    wait_conv(n); chk(n == U * 8, "R5", "period r=0", n, U * 8);
    wr_reg(2'd0, RUN | osr(3));

    // R6 bypass and long average
    cur_req = "R6";
    wr_reg(2'd0, RUN | osr(3) | BYP);
    wait_conv(n); c = code;
    @(negedge clk); #1;
    chk(rdata[9:0] == c && rdata[16], "R6", "bypass publishes sample", rdata, {22'd1 << 6, c});
    wr_reg(2'd0, RUN | osr(3));
    wr_reg(2'd1, 32'd3);
    repeat (120) @(negedge clk);

    // R8 source change
    cur_req = "R8";
    wr_reg(2'd0, RUN | osr(3) | ext(0));
    @(negedge clk); #1;
    chk(!rdata[16], "R8", "valid dropped", rdata, 0);
    chk(sel == 5'd1, "R3", "external sel", 32'(sel), 1);
    wait_conv(n); chk(n == S, "R8", "settle after change", n, S);
    wait_valid();

    // R3 channel ignored in internal mode
    cur_req = "R3";
    wr_reg(2'd0, RUN | osr(3));
    wait_valid();
    wr_reg(2'd0, RUN | osr(3) | (32'd5 << 13));
    repeat (3) @(negedge clk); #1;
    chk(sel == 0 && rdata[16], "R3", "channel ignored internal", {sel, rdata[16]}, 1);
    wr_reg(2'd0, RUN | osr(3) | (32'd1 << 30) | (32'd7 << 13));
    repeat (3) @(negedge clk); #1;
    chk(sel == 0 && rdata[16], "R3", "mode 1 is internal", {sel, rdata[16]}, 1);

    // R12 hold while running
    cur_req = "R12";
    repeat (40) @(negedge clk); #1;
    chk(rdata[16], "R12", "valid stays", rdata, 32'h10000);

    // R9 / R2 stop paths
    cur_req = "R9";
    wr_reg(2'd0, osr(3));
    @(negedge clk); #1; chk(!rdata[16], "R9", "start cleared", rdata, 0);
    n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (conv) n++; end
    chk(n == 0, "R2", "no conv when stopped", n, 0);
    wr_reg(2'd0, RUN | osr(3)); wait_valid();
    wr_reg(2'd0, RUN | 32'h2 | osr(3));
    @(negedge clk); #1; chk(!rdata[16], "R9", "sensor reset", rdata, 0);
    wr_reg(2'd0, RUN | osr(3)); wait_valid();
    wr_reg(2'd0, 32'h1 | osr(3));
    @(negedge clk); #1; chk(!rdata[16], "R2", "enable cleared", rdata, 0);

    // R10 register map
    cur_req = "R10";
    wr_reg(2'd0, RUN | osr(0)); wr_reg(2'd1, 32'd0); wait_valid();
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk(v[16] && (v & ~32'h103FF) == 0, "R10", "status write ignored", v, v & 32'h103FF);
    rd(2'd3, v); chk(v == 0, "R10", "addr 3 zero", v, 0);
    wr_reg(2'd1, 32'hFFFF_FFF9);
    rd(2'd1, v); chk(v == 1, "R10", "ctrl_b width", v, 1);
    rd(2'd0, v); chk(v == (RUN | osr(0)), "R10", "ctrl_a readback", v, RUN | osr(0));

    // R11 signed average
    cur_req = "R11";
    wr_reg(2'd0, RUN | osr(3) | ext(2));
    wait_valid();
    s = rdata;
    chk(s[9:0] == 10'h3FF, "R11", "signed mean", s, 32'h103FF);
    repeat (20) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule